// File: doc/BRIEF.md
# SMM RAM Window Remap Decoder

This block decides, for every CPU memory request, whether the access lands in the system-management RAM window, which DRAM address it is steered to, and whether it goes to DRAM or to the external bus. A 5-bit control register, written over a plain byte-wide write port, enables the window, opens it to non-SMM code, selects one of three window layouts and can mark the physical backing range as guarded. Two of the three layouts relocate a 64 KB slice of DRAM, either from D0000 or from 30000, so that it appears at the legacy B0000 segment. The third maps the 128 KB A0000 segment one-to-one.

Requests enter on a valid/ready channel carrying the address and the SMM-active flag. Each request produces one response on a registered valid/ready channel. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle, so a stalled consumer stalls the producer, and no request is dropped or duplicated. The response comes out one cycle after acceptance and stays stable until `rsp_ready` takes it.

Top module: `smm_remap_top`

## Requirements
- R1: Reset clears the control register. Writes keep bits 4:0 (bit 0 enable, bit 1 open, bits 3:2 window select, bit 4 guard), and `cfg_rdata[7:5]` always reads zero.
- R2: With enable (bit 0) clear, no request is routed to DRAM, whatever the other bits hold.
- R3: Select 00: a CPU address in B0000–BFFFF translates to D0000 plus the offset into the window.
- R4: Select 01: a CPU address in A0000–BFFFF translates to the same address, with `rsp_dram` high.
- R5: Select 10: a CPU address in B0000–BFFFF translates to 30000 plus the offset into the window.
- R6: Select 11 defines no window, so nothing is translated even with enable set.
- R7: An in-window request with `req_smm` low is translated only when the open bit (bit 1) is set. With `req_smm` high it is translated regardless of bit 1.
- R8: With the guard bit (bit 4) set and a defined, enabled window, `rsp_guard` is high for an untranslated request whose address lies in the selected window's physical backing range. In all other cases it is low.
- R9: An untranslated request returns its own address with `rsp_dram` low.
- R10: A register write on a given clock edge affects only requests accepted on later edges. A request accepted on the same edge uses the old value.
- R11: The response is valid one cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the response is held stable and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read-back |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | ADDR_W | CPU memory address |
| req_smm | input | 1 | CPU is in system-management mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | ADDR_W | Translated or passed-through address |
| rsp_dram | output | 1 | 1 = DRAM, 0 = external bus |
| rsp_guard | output | 1 | Access touches the guarded backing range |

## Verification
The assertions check a set of properties on every cycle against the control value and request captured at acceptance:
- upper read-back bits stay zero;
- a disabled window, select 11, or a closed window outside SMM never routes to DRAM;
- any response not routed to DRAM carries the request's own address;
- a stalled response holds still.

Other behaviour depends on specific addresses and write timing, so only the directed scenarios show it:
- the exact translated address for each of the three layouts;
- the window edges, at the first and last byte and one byte outside;
- the guard flag over each backing range;
- the rule that a write lands one request late.

// File: rtl/smm_remap_pkg.sv
package smm_remap_pkg;

  typedef enum logic [1:0] {
    SEL_HI_ALIAS = 2'b00,
    SEL_DIRECT   = 2'b01,
    SEL_LO_ALIAS = 2'b10,
    SEL_NONE     = 2'b11
  } win_sel_e;

  // bit 4 guard, bits 3:2 select, bit 1 open, bit 0 enable
  typedef struct packed {
    logic     guard;
    win_sel_e sel;
    logic     open;
    logic     enable;
  } smm_cfg_t;

  localparam int CFG_W  = $bits(smm_cfg_t);
  localparam int SEG_W  = 20;
  localparam int NUM_WIN = 3;

  typedef struct packed {
    logic [SEG_W-1:0] cpu_base;
    logic [SEG_W-1:0] phys_base;
    logic [4:0]       off_bits;
  } win_desc_t;

  function automatic win_desc_t win_lookup(win_sel_e s);
    win_desc_t d;
    case (s)
      SEL_HI_ALIAS: d = '{cpu_base: 20'hB0000, phys_base: 20'hD0000, off_bits: 5'd16};
      SEL_DIRECT:   d = '{cpu_base: 20'hA0000, phys_base: 20'hA0000, off_bits: 5'd17};
      SEL_LO_ALIAS: d = '{cpu_base: 20'hB0000, phys_base: 20'h30000, off_bits: 5'd16};
      default:      d = '{cpu_base: '0, phys_base: '0, off_bits: 5'd0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/smm_cfg_reg.sv
module smm_cfg_reg
  import smm_remap_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [BUS_W-1:0] wdata,
  output smm_cfg_t         cfg,
  output logic [BUS_W-1:0] rdata
);
  localparam int PAD_W = BUS_W - CFG_W;

  smm_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= smm_cfg_t'(wdata[CFG_W-1:0]);
  end

  assign cfg   = cfg_q;
  assign rdata = {{PAD_W{1'b0}}, cfg_q};
endmodule

// File: rtl/smm_win_decode.sv
module smm_win_decode
  import smm_remap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  smm_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  output logic [ADDR_W-1:0] out_addr,
  output logic              dram,
  output logic              guard
);
  localparam int HI_W = ADDR_W - SEG_W;

  logic [NUM_WIN-1:0] cpu_match;
  logic [NUM_WIN-1:0] phys_match;
  logic [ADDR_W-1:0]  xlat [NUM_WIN];
  logic               below_1m;

  assign below_1m = (addr[ADDR_W-1:SEG_W] == '0);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam win_desc_t D = win_lookup(win_sel_e'(2'(g)));
    logic [SEG_W-1:0] mask;
    assign mask          = (SEG_W'(1) << D.off_bits) - SEG_W'(1);
    assign cpu_match[g]  = below_1m && ((addr[SEG_W-1:0] & ~mask) == D.cpu_base);
    assign phys_match[g] = below_1m && ((addr[SEG_W-1:0] & ~mask) == D.phys_base);
    assign xlat[g]       = {{HI_W{1'b0}}, D.phys_base | (addr[SEG_W-1:0] & mask)};
  end

  logic win_on, in_cpu, in_phys, reachable;
  logic [ADDR_W-1:0] sel_xlat;

  always_comb begin
    in_cpu   = 1'b0;
    in_phys  = 1'b0;
    sel_xlat = addr;
    win_on   = cfg.enable && (cfg.sel != SEL_NONE);
    case (cfg.sel)
      SEL_HI_ALIAS: begin in_cpu = cpu_match[0]; in_phys = phys_match[0]; sel_xlat = xlat[0]; end
      SEL_DIRECT:   begin in_cpu = cpu_match[1]; in_phys = phys_match[1]; sel_xlat = xlat[1]; end
      SEL_LO_ALIAS: begin in_cpu = cpu_match[2]; in_phys = phys_match[2]; sel_xlat = xlat[2]; end
      default:      ;
    endcase
    reachable = smm || cfg.open;
    dram      = win_on && in_cpu && reachable;
    out_addr  = dram ? sel_xlat : addr;
    guard     = win_on && cfg.guard && in_phys && !dram;
  end
endmodule

// File: rtl/smm_rsp_stage.sv
module smm_rsp_stage #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        valid_q <= 1'b0;
    else if (in_ready) valid_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     data_q <= '0;
    else if (in_ready && in_valid)  data_q <= in_data;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/smm_remap_top.sv
module smm_remap_top
  import smm_remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BUS_W-1:0]  cfg_wdata,
  output logic [BUS_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_smm,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_dram,
  output logic              rsp_guard
);
  localparam int PAY_W = ADDR_W + 2;

  smm_cfg_t          cfg;
  logic [ADDR_W-1:0] dec_addr;
  logic              dec_dram, dec_guard;
  logic [PAY_W-1:0]  pay_out;

  smm_cfg_reg #(.BUS_W(BUS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  smm_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cfg(cfg), .addr(req_addr), .smm(req_smm),
    .out_addr(dec_addr), .dram(dec_dram), .guard(dec_guard)
  );

  smm_rsp_stage #(.W(PAY_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_data({dec_dram, dec_guard, dec_addr}),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pay_out)
  );

  assign rsp_dram  = pay_out[PAY_W-1];
  assign rsp_guard = pay_out[PAY_W-2];
  assign rsp_addr  = pay_out[ADDR_W-1:0];
endmodule

// File: rtl/smm_remap_chk.sv
module smm_remap_chk #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [BUS_W-1:0]  cfg_wdata,
  input logic [BUS_W-1:0]  cfg_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_smm,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_dram,
  input logic              rsp_guard
);
  logic [ADDR_W-1:0] cap_addr;
  logic [BUS_W-1:0]  cap_cfg;
  logic              cap_smm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0; cap_cfg <= '0; cap_smm <= 1'b0;
    end else if (req_valid && req_ready) begin
      cap_addr <= req_addr; cap_cfg <= cfg_rdata; cap_smm <= req_smm;
    end
  end

  AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[BUS_W-1:5] == '0); // R1
  AST_OFF_NO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !cap_cfg[0] |-> !rsp_dram); // R2
  AST_NO_WINDOW_NO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (cap_cfg[3:2] == 2'b11) |-> !rsp_dram); // R6
  AST_CLOSED_OUTSIDE_SMM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !cap_smm && !cap_cfg[1] |-> !rsp_dram); // R7
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_dram |-> rsp_addr == cap_addr); // R9
  AST_GUARD_NOT_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_guard |-> !rsp_dram && cap_cfg[4]); // R8
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_dram) && $stable(rsp_guard)); // R11
  AST_NO_ACCEPT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R11
endmodule

bind smm_remap_top smm_remap_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/smm_remap_top_bench.sv
module smm_remap_top_bench;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic req_valid = 1'b0, req_ready, req_smm = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_dram, rsp_guard;
  logic [AW-1:0] rsp_addr;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] shadow_cfg = '0;

  always #2 clk = ~clk;

  smm_remap_top u_smm_remap_top (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected routing computed from the requirement text
  task automatic model(input logic [7:0] c, input logic [AW-1:0] a, input logic s,
                       output logic [AW-1:0] ea, output logic ed, output logic eg);
    logic [AW-1:0] lo, sz, pb;
    logic defd;
    defd = 1'b1;
    case (c[3:2])
      2'b00:   begin lo = 32'hB0000; sz = 32'h10000; pb = 32'hD0000; end
      2'b01:   begin lo = 32'hA0000; sz = 32'h20000; pb = 32'hA0000; end
      2'b10:   begin lo = 32'hB0000; sz = 32'h10000; pb = 32'h30000; end
      default: begin lo = 0; sz = 0; pb = 0; defd = 1'b0; end
    endcase
    ed = c[0] && defd && (a >= lo) && (a < lo + sz) && (s || c[1]);
    ea = ed ? pb + (a - lo) : a;
    eg = c[0] && defd && c[4] && !ed && (a >= pb) && (a < pb + sz);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    shadow_cfg = v & 8'h1f;
  endtask

  task automatic access(string req, input logic [AW-1:0] a, input logic s);
    logic [AW-1:0] ea; logic ed, eg;
    model(shadow_cfg, a, s, ea, ed, eg);
    @(negedge clk); req_valid = 1'b1; req_addr = a; req_smm = s;
    @(negedge clk); req_valid = 1'b0;
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " addr"},  64'(rsp_addr),  64'(ea));
    check({req, " dram"},  64'(rsp_dram),  64'(ed));
    check({req, " guard"}, 64'(rsp_guard), 64'(eg));
  endtask

  task automatic t_reset;
    check("R1 reset cfg", 64'(cfg_rdata), 64'd0);
    check("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
    wr_cfg(8'hFF);
    check("R1 upper bits zero", 64'(cfg_rdata), 64'h1F);
    wr_cfg(8'h00);
  endtask

  task automatic t_disabled;
    wr_cfg(8'h1E); // select 11 ignored; also select 00 variants with enable clear
    access("R2 off b0000", 32'hB1234, 1'b1);
    wr_cfg(8'h02);
    access("R2 off sel00", 32'hB0000, 1'b1);
  endtask

  task automatic t_sel00;
    wr_cfg(8'h01);
    access("R3 first", 32'hB0000, 1'b1);
    access("R3 last",  32'hBFFFF, 1'b1);
    access("R3 mid",   32'hB4321, 1'b1);
    access("R3 below", 32'hAFFFF, 1'b1);
    access("R9 above", 32'hC0000, 1'b1);
    access("R9 high",  32'h100B0000, 1'b1);
  endtask

  task automatic t_sel01;
    wr_cfg(8'h05);
    access("R4 first", 32'hA0000, 1'b1);
    access("R4 last",  32'hBFFFF, 1'b1);
    access("R4 out",   32'hC0000, 1'b1);
  endtask

  task automatic t_sel10;
    wr_cfg(8'h09);
    access("R5 first", 32'hB0000, 1'b1);
    access("R5 mid",   32'hBABCD, 1'b1);
    access("R5 backing direct", 32'h30010, 1'b1);
  endtask

  task automatic t_sel11;
    wr_cfg(8'h0F);
    access("R6 b0000", 32'hB0000, 1'b1);
    access("R6 a0000", 32'hA0000, 1'b0);
  endtask

  task automatic t_open;
    wr_cfg(8'h01);
    access("R7 closed nosmm", 32'hB0100, 1'b0);
    wr_cfg(8'h03);
    access("R7 open nosmm", 32'hB0100, 1'b0);
  endtask

  task automatic t_guard;
    wr_cfg(8'h11);
    access("R8 hi backing", 32'hD1234, 1'b0);
    access("R8 hit no guard", 32'hB1234, 1'b1);
    wr_cfg(8'h15);
    access("R8 direct closed", 32'hA8000, 1'b0);
    wr_cfg(8'h19);
    access("R8 lo backing", 32'h3FFFF, 1'b1);
    access("R8 outside", 32'h40000, 1'b1);
    wr_cfg(8'h01);
    access("R8 guard off", 32'hD1234, 1'b0);
  endtask

  task automatic t_write_timing;
    wr_cfg(8'h00);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'h01;
    req_valid = 1'b1; req_addr = 32'hB0040; req_smm = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R10 same edge old cfg dram", 64'(rsp_dram), 64'd0);
    check("R10 same edge old cfg addr", 64'(rsp_addr), 64'hB0040);
    shadow_cfg = 8'h01;
    access("R10 next request", 32'hB0040, 1'b1);
  endtask

  task automatic t_stall;
    wr_cfg(8'h01);
    rsp_ready = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_addr = 32'hB0002; req_smm = 1'b1;
    @(negedge clk);
    req_addr = 32'hB0008;
    for (int i = 0; i < 3; i++) begin
      check("R11 held valid", 64'(rsp_valid), 64'd1);
      check("R11 held addr", 64'(rsp_addr), 64'hD0002);
      check("R11 not ready", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check("R11 next after drain", 64'(rsp_addr), 64'hD0008);
    @(negedge clk);
    check("R11 empty", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_sel00();
    t_sel01();
    t_sel10();
    t_sel11();
    t_open();
    t_guard();
    t_write_timing();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule